// File: doc/BRIEF.md
# Configurable Multi-Source GPIO Port

This block is an eight-pin I/O port for a companion device that sits beside a microcontroller. Each pin is set up on its own, so one port can mix functions at the same time. Every pin drives its output from one of four sources:

- a host-written data register;
- a latched address bit;
- an output from the programmable logic array;
- an external chip-select line.

Static configuration picks the source, and a run-time control bit can override that choice. Each pin's driver enable combines a direction bit with an optional enable term from the logic array.

The host reaches the port through a small register window with write and read strobes. A read goes through a two-state readback machine. That machine puts exactly one source on the internal data bus, and it keeps the bus at zero with its enable low when no read is in progress.

Each pin also has an input macrocell. It feeds the logic-array input bus and works in one of three ways:

- as a direct pass-through;
- as a transparent latch;
- as an edge register.

The latch and the register are clocked either by the address strobe or by a per-pin product-term clock. The host can read the macrocell outputs. The register decode and the logic array are outside this block, and all array signals arrive as plain ports.

Readback state machine:

- States: `RB_IDLE` (bus released, data zero) and `RB_DRIVE` (bus driven with one selected source).
- Transition `RB_IDLE -> RB_DRIVE`: the read strobe is high.
- Transition `RB_DRIVE -> RB_DRIVE`: the read strobe stays high, and the data is refreshed every cycle.
- Transition `RB_DRIVE -> RB_IDLE`: the read strobe is low.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the data-out, direction and control registers read 0. With no array enable term defined, every `pin_oe` bit is 0 and `host_rdata_oe` is 0.
- R2: With its control bit clear, pin i drives the source that `cfg_src[2i+1:2i]` names: 0 = data-out bit, 1 = latched address bit, 2 = array macrocell bit, 3 = chip-select bit.
- R3: When control bit i is 1, pin i drives the latched address bit, whatever `cfg_src` holds.
- R4: `pin_oe[i]` is 1 exactly when direction bit i is 1, or when both `cfg_pt_def[i]` and `pt_oe_i[i]` are 1. When `cfg_pt_def[i]` is 0, the direction bit alone decides.
- R5: A write with `host_wr` high updates the register chosen by `host_addr` at that clock edge: 0 = data-out, 1 = direction, 2 = control. A later read of the same address returns the written value.
- R6: A clock edge with `host_rd` high moves the readback machine to `RB_DRIVE`, and the selected value appears on `host_rdata` with `host_rdata_oe` high after that edge. An edge with `host_rd` low returns the machine to `RB_IDLE`, where `host_rdata` is 0 and `host_rdata_oe` is 0.
- R7: Input macrocell mode 0 (direct) or mode 3 passes `pin_i[i]` straight to `imc_o[i]` with no clock.
- R8: In mode 1 (latch), `imc_o[i]` follows `pin_i[i]` while the selected strobe is high. It holds the value sampled at the last clock edge on which the strobe was high.
- R9: In mode 2 (edge register), `imc_o[i]` takes `pin_i[i]` only at a clock edge where the selected strobe is 1 and was 0 at the previous edge. Otherwise it holds.
- R10: `cfg_imc_clksel[i]` = 0 clocks macrocell i from `as_i`, and 1 clocks it from `pt_clk_i[i]`. The strobe that is not selected has no effect.
- R11: Read addresses 3, 4 and 5 return the array macrocell inputs, the live pin inputs and the input macrocell outputs.
- R12: Writes to addresses 3 to 7 change no register. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2*PINS | Static output source code per pin |
| cfg_pt_def | input | PINS | An array enable term is defined for the pin |
| cfg_imc_mode | input | 2*PINS | Input macrocell mode per pin |
| cfg_imc_clksel | input | PINS | Macrocell strobe select (0 address strobe, 1 product term) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register select |
| host_wdata | input | PINS | Host write data |
| host_rdata | output | PINS | Internal data bus readback |
| host_rdata_oe | output | 1 | Readback bus enable |
| addr_lat_i | input | PINS | Latched address bits |
| mcell_i | input | PINS | Array macrocell outputs |
| chipsel_i | input | PINS | External chip-select lines |
| pt_oe_i | input | PINS | Array enable product terms |
| as_i | input | 1 | Address strobe |
| pt_clk_i | input | PINS | Per-pin product-term clocks |
| pin_i | input | PINS | Pin input level |
| pin_o | output | PINS | Pin output value |
| pin_oe | output | PINS | Pin driver enable |
| imc_o | output | PINS | Input macrocell outputs to the array bus |

## Verification
The bench walks vectors in which pins of one port mix all four sources. One vector sets control bits over a source code that points elsewhere; a design that ignored the override would drive macrocell data on those pins. Enable terms are driven both with and without their definition bit, which catches an enable that skips the definition gate or drops the direction bit.

The macrocell sequence raises the address strobe while the pin's own product-term clock stays low. A design that ignored the clock select would then capture too early. The sequence also changes pin data while the strobe is still high, and a design that treated a high level as an edge would follow that change. Reads check that the bus falls back to zero after the read strobe drops, and that writes to unmapped addresses leave every register untouched.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [1:0] {
        SRC_DOUT    = 2'd0,
        SRC_ADDR    = 2'd1,
        SRC_MCELL   = 2'd2,
        SRC_CHIPSEL = 2'd3
    } out_src_e;

    typedef enum logic [1:0] {
        IMC_DIRECT = 2'd0,
        IMC_LATCH  = 2'd1,
        IMC_EDGE   = 2'd2,
        IMC_PASS   = 2'd3
    } imc_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT  = 3'd0,
        RA_DIR   = 3'd1,
        RA_CTRL  = 3'd2,
        RA_MCELL = 3'd3,
        RA_PIN   = 3'd4,
        RA_IMC   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        RB_IDLE  = 1'b0,
        RB_DRIVE = 1'b1
    } rb_state_e;

endpackage

// File: rtl/gpio_pin_outmux.sv
module gpio_pin_outmux
    import gpio_port_pkg::*;
#(
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic [1:0] cfg_src,
    input  logic       ctrl_bit,
    input  logic       dout_bit,
    input  logic       addr_bit,
    input  logic       mcell_bit,
    input  logic       cs_bit,
    input  logic       dir_bit,
    input  logic       pt_def,
    input  logic       pt_oe,
    output logic       pin_o,
    output logic       pin_oe
);

    out_src_e sel;

    generate
        if (HAS_CTRL) begin : g_ctrl
            always_comb begin
                if (ctrl_bit) begin
                    sel = SRC_ADDR;
                end else begin
                    sel = out_src_e'(cfg_src);
                end
            end
        end else begin : g_noctrl
            logic unused_ctrl;
            assign unused_ctrl = ctrl_bit;
            always_comb sel = out_src_e'(cfg_src);
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SRC_DOUT:    pin_o = dout_bit;
            SRC_ADDR:    pin_o = addr_bit;
            SRC_MCELL:   pin_o = mcell_bit;
            SRC_CHIPSEL: pin_o = cs_bit;
        endcase
    end

    assign pin_oe = dir_bit | (pt_def & pt_oe);

endmodule

// File: rtl/gpio_in_macrocell.sv
module gpio_in_macrocell
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       clk_sel,
    input  logic       as_i,
    input  logic       pt_clk_i,
    input  logic       pin_i,
    output logic       imc_o
);

    imc_mode_e mode_e;
    logic      strobe;
    logic      strobe_prev;
    logic      cap_q;
    logic      rise;

    assign mode_e = imc_mode_e'(mode);
    assign strobe = clk_sel ? pt_clk_i : as_i;
    assign rise   = strobe & ~strobe_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
        end else begin
            strobe_prev <= strobe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else begin
            unique case (mode_e)
                IMC_LATCH: if (strobe) cap_q <= pin_i;
                IMC_EDGE:  if (rise)   cap_q <= pin_i;
                IMC_DIRECT, IMC_PASS: cap_q <= cap_q;
            endcase
        end
    end

    always_comb begin
        unique case (mode_e)
            IMC_LATCH:            imc_o = strobe ? pin_i : cap_q;
            IMC_EDGE:             imc_o = cap_q;
            IMC_DIRECT, IMC_PASS: imc_o = pin_i;
        endcase
    end

    // R9
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == IMC_EDGE && !rise) |=> (mode_e != IMC_EDGE) || (imc_o == $past(imc_o)));

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      src_dout,
    input  logic [W-1:0]      src_dir,
    input  logic [W-1:0]      src_ctrl,
    input  logic [W-1:0]      src_mcell,
    input  logic [W-1:0]      src_pin,
    input  logic [W-1:0]      src_imc,
    output logic [W-1:0]      rdata,
    output logic              rdata_oe
);

    rb_state_e    state_q, state_d;
    logic [W-1:0] sel_data;
    logic [W-1:0] data_q;

    always_comb begin
        case (addr)
            RA_DOUT:  sel_data = src_dout;
            RA_DIR:   sel_data = src_dir;
            RA_CTRL:  sel_data = src_ctrl;
            RA_MCELL: sel_data = src_mcell;
            RA_PIN:   sel_data = src_pin;
            RA_IMC:   sel_data = src_imc;
            default:  sel_data = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RB_IDLE:  state_d = rd ? RB_DRIVE : RB_IDLE;
            RB_DRIVE: state_d = rd ? RB_DRIVE : RB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd) begin
                data_q <= sel_data;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RB_IDLE: begin
                rdata_oe = 1'b0;
                rdata    = '0;
            end
            RB_DRIVE: begin
                rdata_oe = 1'b1;
                rdata    = data_q;
            end
        endcase
    end

    // R6
    rb_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R6
    rb_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rdata_oe);

    // R6
    rb_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rdata_oe);

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS     = 8,
    parameter bit          HAS_CTRL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*PINS-1:0]   cfg_src,
    input  logic [PINS-1:0]     cfg_pt_def,
    input  logic [2*PINS-1:0]   cfg_imc_mode,
    input  logic [PINS-1:0]     cfg_imc_clksel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [PINS-1:0]     host_wdata,
    output logic [PINS-1:0]     host_rdata,
    output logic                host_rdata_oe,
    input  logic [PINS-1:0]     addr_lat_i,
    input  logic [PINS-1:0]     mcell_i,
    input  logic [PINS-1:0]     chipsel_i,
    input  logic [PINS-1:0]     pt_oe_i,
    input  logic                as_i,
    input  logic [PINS-1:0]     pt_clk_i,
    input  logic [PINS-1:0]     pin_i,
    output logic [PINS-1:0]     pin_o,
    output logic [PINS-1:0]     pin_oe,
    output logic [PINS-1:0]     imc_o
);

    logic [PINS-1:0] dout_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else if (host_wr) begin
            case (host_addr)
                RA_DOUT: dout_q <= host_wdata;
                RA_DIR:  dir_q  <= host_wdata;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_CTRL) begin : g_ctrl_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctrl_q <= '0;
                end else if (host_wr && host_addr == RA_CTRL) begin
                    ctrl_q <= host_wdata;
                end
            end
        end else begin : g_no_ctrl_reg
            assign ctrl_q = '0;
        end
    endgenerate

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_pin_outmux #(
            .HAS_CTRL (HAS_CTRL)
        ) u_outmux (
            .cfg_src   (cfg_src[2*i +: 2]),
            .ctrl_bit  (ctrl_q[i]),
            .dout_bit  (dout_q[i]),
            .addr_bit  (addr_lat_i[i]),
            .mcell_bit (mcell_i[i]),
            .cs_bit    (chipsel_i[i]),
            .dir_bit   (dir_q[i]),
            .pt_def    (cfg_pt_def[i]),
            .pt_oe     (pt_oe_i[i]),
            .pin_o     (pin_o[i]),
            .pin_oe    (pin_oe[i])
        );

        gpio_in_macrocell u_imc (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (cfg_imc_mode[2*i +: 2]),
            .clk_sel  (cfg_imc_clksel[i]),
            .as_i     (as_i),
            .pt_clk_i (pt_clk_i[i]),
            .pin_i    (pin_i[i]),
            .imc_o    (imc_o[i])
        );
    end

    gpio_readback #(
        .W (PINS)
    ) u_readback (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .addr      (host_addr),
        .src_dout  (dout_q),
        .src_dir   (dir_q),
        .src_ctrl  (ctrl_q),
        .src_mcell (mcell_i),
        .src_pin   (pin_i),
        .src_imc   (imc_o),
        .rdata     (host_rdata),
        .rdata_oe  (host_rdata_oe)
    );

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == RA_DIR) |=> (dir_q == $past(host_wdata)));

    // R5
    dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == RA_DOUT) |=> (dout_q == $past(host_wdata)));

    // R12
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr > RA_CTRL) |=> ($stable(dout_q) && $stable(dir_q) && $stable(ctrl_q)));

endmodule

// File: tb/gpio_mux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;

    localparam int PINS = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2*PINS-1:0] cfg_src = '0;
    logic [PINS-1:0]   cfg_pt_def = '0;
    logic [2*PINS-1:0] cfg_imc_mode = 16'h01A4;
    logic [PINS-1:0]   cfg_imc_clksel = 8'h18;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [2:0]        host_addr = '0;
    logic [PINS-1:0]   host_wdata = '0;
    logic [PINS-1:0]   host_rdata;
    logic              host_rdata_oe;
    logic [PINS-1:0]   addr_lat_i = '0;
    logic [PINS-1:0]   mcell_i = '0;
    logic [PINS-1:0]   chipsel_i = '0;
    logic [PINS-1:0]   pt_oe_i = '0;
    logic              as_i = 1'b0;
    logic [PINS-1:0]   pt_clk_i = '0;
    logic [PINS-1:0]   pin_i = '0;
    logic [PINS-1:0]   pin_o;
    logic [PINS-1:0]   pin_oe;
    logic [PINS-1:0]   imc_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_mux_port #(.PINS(PINS), .HAS_CTRL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_pt_def(cfg_pt_def),
        .cfg_imc_mode(cfg_imc_mode), .cfg_imc_clksel(cfg_imc_clksel),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .addr_lat_i(addr_lat_i), .mcell_i(mcell_i), .chipsel_i(chipsel_i),
        .pt_oe_i(pt_oe_i), .as_i(as_i), .pt_clk_i(pt_clk_i), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .imc_o(imc_o)
    );

    // Fields: src[79:64] ctrl dout dir addr mcell cs ptdef pt
    localparam logic [79:0] VECS [4] = '{
        {16'h0000, 8'h00, 8'hA5, 8'hFF, 8'h3C, 8'h0F, 8'hF0, 8'h00, 8'hFF},
        {16'h5555, 8'h00, 8'h00, 8'h0F, 8'hC3, 8'h00, 8'h00, 8'hF0, 8'h30},
        {16'hE4E4, 8'h00, 8'h11, 8'h00, 8'h22, 8'h44, 8'h88, 8'hFF, 8'h81},
        {16'hAAAA, 8'h0F, 8'h00, 8'h55, 8'h5A, 8'h99, 8'h00, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        d = host_rdata; oe = host_rdata_oe;
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] model_pin(logic [15:0] src, logic [7:0] ctrl, logic [7:0] dout,
                                             logic [7:0] adr, logic [7:0] mc, logic [7:0] cs);
        logic [7:0] r;
        logic [1:0] s;
        for (int i = 0; i < 8; i++) begin
            s = ctrl[i] ? 2'd1 : src[2*i +: 2];
            case (s)
                2'd0: r[i] = dout[i];
                2'd1: r[i] = adr[i];
                2'd2: r[i] = mc[i];
                default: r[i] = cs[i];
            endcase
        end
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd_d;
        logic       rd_oe;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 rdata_oe", {7'd0, host_rdata_oe}, 8'h00);
        host_read(3'd0, rd_d, rd_oe); chk("R1 dout", rd_d, 8'h00);
        host_read(3'd1, rd_d, rd_oe); chk("R1 dir", rd_d, 8'h00);
        host_read(3'd2, rd_d, rd_oe); chk("R1 ctrl", rd_d, 8'h00);

        // R2 R3 R4 vector walk
        for (int v = 0; v < 4; v++) begin
            logic [79:0] e;
            e = VECS[v];
            host_write(3'd0, e[55:48]);
            host_write(3'd1, e[47:40]);
            host_write(3'd2, e[63:56]);
            @(negedge clk);
            cfg_src = e[79:64]; addr_lat_i = e[39:32]; mcell_i = e[31:24];
            chipsel_i = e[23:16]; cfg_pt_def = e[15:8]; pt_oe_i = e[7:0];
            #1;
            chk("R2/R3 pin_o", pin_o,
                model_pin(e[79:64], e[63:56], e[55:48], e[39:32], e[31:24], e[23:16]));
            chk("R4 pin_oe", pin_oe, e[47:40] | (e[15:8] & e[7:0]));
            host_read(3'd2, rd_d, rd_oe);
            chk("R5 ctrl readback", rd_d, e[63:56]);
        end

        // R5 write then read back
        host_write(3'd0, 8'h3C);
        host_write(3'd1, 8'hC6);
        host_read(3'd0, rd_d, rd_oe); chk("R5 dout", rd_d, 8'h3C);
        chk("R6 oe in drive", {7'd0, rd_oe}, 8'h01);
        host_read(3'd1, rd_d, rd_oe); chk("R5 dir", rd_d, 8'hC6);

        // R6 bus released after read ends
        @(negedge clk);
        chk("R6 idle oe", {7'd0, host_rdata_oe}, 8'h00);
        chk("R6 idle data", host_rdata, 8'h00);

        // R12 unmapped writes ignored, unmapped reads zero
        host_write(3'd6, 8'hFF);
        host_write(3'd3, 8'hFF);
        host_read(3'd0, rd_d, rd_oe); chk("R12 dout kept", rd_d, 8'h3C);
        host_read(3'd1, rd_d, rd_oe); chk("R12 dir kept", rd_d, 8'hC6);
        host_read(3'd2, rd_d, rd_oe); chk("R12 ctrl kept", rd_d, 8'h0F);
        host_read(3'd6, rd_d, rd_oe); chk("R12 read zero", rd_d, 8'h00);

        // R11 array macrocell readback
        host_read(3'd3, rd_d, rd_oe); chk("R11 mcell", rd_d, 8'h99);

        // R7 direct mode on pin0
        @(negedge clk); pin_i = 8'h01; #1;
        chk("R7 direct high", {7'd0, imc_o[0]}, 8'h01);
        pin_i = 8'h00; #1;
        chk("R7 direct low", {7'd0, imc_o[0]}, 8'h00);

        // R9 no strobe, no capture on pin2
        @(negedge clk); pin_i = 8'h04;
        @(negedge clk);
        chk("R9 no strobe", {7'd0, imc_o[2]}, 8'h00);

        // address strobe rises
        as_i = 1'b1; pin_i = 8'h0E; #1;
        chk("R8 latch transparent", {7'd0, imc_o[1]}, 8'h01);
        chk("R9 before edge", {7'd0, imc_o[2]}, 8'h00);
        @(negedge clk);
        chk("R9 captured", {7'd0, imc_o[2]}, 8'h01);
        chk("R10 other strobe ignored", {7'd0, imc_o[3]}, 8'h00);
        pin_i = 8'h02; #1;
        chk("R9 level not edge", {7'd0, imc_o[2]}, 8'h01);
        @(negedge clk);
        as_i = 1'b0; pin_i = 8'h00; #1;
        chk("R8 latch hold", {7'd0, imc_o[1]}, 8'h01);

        // R10 product-term clock on pin3
        @(negedge clk); pin_i = 8'h08;
        @(negedge clk); pt_clk_i = 8'h08;
        @(negedge clk);
        chk("R10 pt clock capture", {7'd0, imc_o[3]}, 8'h01);
        chk("R11 imc vector", imc_o, 8'h0E);
        host_read(3'd5, rd_d, rd_oe); chk("R11 imc readback", rd_d, 8'h0E);
        host_read(3'd4, rd_d, rd_oe); chk("R11 pin readback", rd_d, 8'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule